// File: doc/BRIEF.md
# Sequential Flag-Offset Register Loader

This block keeps the four offset values that a synchronous FIFO's almost-empty and almost-full flag logic compares against the pointer difference. The four registers are empty-low, empty-high, full-low and full-high. They are reached over the FIFO's own data bus while a shared load pin is held low. A single rotating selector picks the register for each access. The flag logic receives the assembled empty and full offsets.

The load pin doubles as a configuration input. Its level on the first rising clock edge after reset release picks one of two configurations. In programming configuration, load low turns write-enable and read-enable into register accesses, and load high leaves them as normal FIFO requests. In expansion configuration, offset access is closed for good and the pin no longer affects the requests.

Top module: `flag_ofs_loader`

## Requirements
- R1: While reset is asserted and after its release, empty_ofs and full_ofs are both 7 and cfg_q is 0. The low registers reset to 7 and the high registers reset to 0.
- R2: The first rising edge after reset release samples ld_n and performs no other operation. If ld_n is low, prog_mode becomes 1. If ld_n is high, prog_mode stays 0, the offsets never change, and fifo_wr_req and fifo_rd_req follow the enables whatever ld_n does.
- R3: In programming configuration, each edge with ld_n low and wr_en_n low stores din into the selected register and advances the selector. The order is empty-low, empty-high, full-low, full-high. Each offset is {high[OFS_W-DATA_W-1:0], low[DATA_W-1:0]}.
- R4: The fifth write of a session goes back to the empty-low register.
- R5: Raising ld_n does not move the selector. The next load session continues at the register after the last one accessed.
- R6: Each edge with ld_n low, rd_en_n low and wr_en_n high loads the selected register into cfg_q one cycle later. It steps the same selector in the same order and leaves the offsets unchanged.
- R7: When ld_n, wr_en_n and rd_en_n are all low, the write is performed and the read is ignored. cfg_q holds and the selector advances once.
- R8: An edge with ld_n low and both enables high changes no register, no offset and no selector position.
- R9: In programming configuration, fifo_wr_req equals NOT wr_en_n and fifo_rd_req equals NOT rd_en_n while ld_n is high. Both are 0 while ld_n is low, and both are 0 before the configuration edge.
- R10: A new reset returns the selector to the empty-low register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_n | input | 1 | Load / configuration pin, active low |
| wr_en_n | input | 1 | Write enable, active low |
| rd_en_n | input | 1 | Read enable, active low |
| din | input | DATA_W | Shared data input |
| cfg_q | output | DATA_W | Offset register readback |
| empty_ofs | output | OFS_W | Assembled almost-empty offset |
| full_ofs | output | OFS_W | Assembled almost-full offset |
| prog_mode | output | 1 | 1 when offset programming is enabled |
| fifo_wr_req | output | 1 | Qualified FIFO write request |
| fifo_rd_req | output | 1 | Qualified FIFO read request |

## Verification
The selector position cannot be seen at the ports. It shows up only through where the next write lands or which register the next read returns. The stimulus therefore interleaves partial write sessions, normal FIFO cycles and readback runs. Every later access then depends on the selector having kept and wrapped its position correctly. A combined read-and-write cycle is followed by a readback run that shows the selector moved only once. A second reset in the middle of a session shows the selector returning to empty-low.

// File: rtl/flag_ofs_pkg.sv
package flag_ofs_pkg;
  localparam int NUM_OFS = 4;
  typedef enum logic [1:0] {
    SEL_E_LO = 2'd0,
    SEL_E_HI = 2'd1,
    SEL_F_LO = 2'd2,
    SEL_F_HI = 2'd3
  } ofs_sel_e;
endpackage

// File: rtl/ofs_mode_capture.sv
module ofs_mode_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_pin_n,
  output logic armed,
  output logic prog_en
);
  logic armed_d, prog_d;

  always_comb begin
    armed_d = 1'b1;
    prog_d  = armed ? prog_en : ~mode_pin_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      prog_en <= 1'b0;
    end else begin
      armed   <= armed_d;
      prog_en <= prog_d;
    end
  end
endmodule

// File: rtl/ofs_selector.sv
module ofs_selector
  import flag_ofs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     step,
  output ofs_sel_e sel
);
  ofs_sel_e sel_d;

  always_comb begin
    sel_d = sel;
    if (step) sel_d = ofs_sel_e'(sel + 2'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel <= SEL_E_LO;
    else        sel <= sel_d;
  end
endmodule

// File: rtl/ofs_bank.sv
module ofs_bank
  import flag_ofs_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int LO_RST = 7,
  parameter int HI_RST = 0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic                            rd_en,
  input  ofs_sel_e                        sel,
  input  logic [DATA_W-1:0]               wr_data,
  output logic [NUM_OFS-1:0][DATA_W-1:0]  regs,
  output logic [DATA_W-1:0]               rd_q
);
  for (genvar g = 0; g < NUM_OFS; g++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_V =
      (g % 2 == 0) ? DATA_W'(LO_RST) : DATA_W'(HI_RST);
    logic             hit;
    logic [DATA_W-1:0] reg_d;
    always_comb begin
      hit   = wr_en && (sel == ofs_sel_e'(g));
      reg_d = hit ? wr_data : regs[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[g] <= RST_V;
      else        regs[g] <= reg_d;
    end
  end

  logic [DATA_W-1:0] rd_d;
  always_comb rd_d = rd_en ? regs[sel] : rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end
endmodule

// File: rtl/flag_ofs_loader.sv
module flag_ofs_loader
  import flag_ofs_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int OFS_W  = 16,
  parameter int LO_RST = 7,
  parameter int HI_RST = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_n,
  input  logic              wr_en_n,
  input  logic              rd_en_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] cfg_q,
  output logic [OFS_W-1:0]  empty_ofs,
  output logic [OFS_W-1:0]  full_ofs,
  output logic              prog_mode,
  output logic              fifo_wr_req,
  output logic              fifo_rd_req
);
  localparam int HI_W = OFS_W - DATA_W;

  logic     armed;
  logic     load_win;
  logic     cfg_wr, cfg_rd;
  ofs_sel_e sel;
  logic [NUM_OFS-1:0][DATA_W-1:0] regs;

  ofs_mode_capture u_mode (
    .clk(clk), .rst_n(rst_n), .mode_pin_n(ld_n),
    .armed(armed), .prog_en(prog_mode)
  );

  always_comb begin
    load_win    = prog_mode && !ld_n;
    cfg_wr      = load_win && !wr_en_n;
    cfg_rd      = load_win && !rd_en_n && !cfg_wr;
    fifo_wr_req = armed && !wr_en_n && !load_win;
    fifo_rd_req = armed && !rd_en_n && !load_win;
  end

  ofs_selector u_sel (
    .clk(clk), .rst_n(rst_n), .step(cfg_wr || cfg_rd), .sel(sel)
  );

  ofs_bank #(.DATA_W(DATA_W), .LO_RST(LO_RST), .HI_RST(HI_RST)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .rd_en(cfg_rd),
    .sel(sel), .wr_data(din), .regs(regs), .rd_q(cfg_q)
  );

  always_comb begin
    empty_ofs = {regs[SEL_E_HI][HI_W-1:0], regs[SEL_E_LO]};
    full_ofs  = {regs[SEL_F_HI][HI_W-1:0], regs[SEL_F_LO]};
  end

  logic unused_hi_bits;
  assign unused_hi_bits = ^{regs[SEL_E_HI][DATA_W-1:HI_W], regs[SEL_F_HI][DATA_W-1:HI_W]};
endmodule

// File: rtl/flag_ofs_loader_chk.sv
module flag_ofs_loader_chk #(
  parameter int DATA_W = 9,
  parameter int OFS_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_n,
  input logic              wr_en_n,
  input logic              rd_en_n,
  input logic              armed,
  input logic [DATA_W-1:0] cfg_q,
  input logic [OFS_W-1:0]  empty_ofs,
  input logic [OFS_W-1:0]  full_ofs,
  input logic              prog_mode,
  input logic              fifo_wr_req,
  input logic              fifo_rd_req
);
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_mode && !ld_n && wr_en_n && rd_en_n)
      |=> ($stable(empty_ofs) && $stable(full_ofs) && $stable(cfg_q)));

  a_r9_no_fifo_in_load: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_mode && !ld_n) |-> (!fifo_wr_req && !fifo_rd_req));

  a_r2_expansion_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_mode |=> ($stable(empty_ofs) && $stable(full_ofs)));

  a_r2_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> $stable(prog_mode));

  a_r7_read_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_mode && !ld_n && !wr_en_n && !rd_en_n) |=> $stable(cfg_q));

  a_r6_read_keeps_ofs: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_mode && !ld_n && wr_en_n && !rd_en_n)
      |=> ($stable(empty_ofs) && $stable(full_ofs)));
endmodule

bind flag_ofs_loader flag_ofs_loader_chk #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n),
  .armed(armed), .cfg_q(cfg_q), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
  .prog_mode(prog_mode), .fifo_wr_req(fifo_wr_req), .fifo_rd_req(fifo_rd_req)
);

// File: tb/flag_ofs_loader_test.sv
`timescale 1ns/1ps
module flag_ofs_loader_test;
  localparam int DATA_W = 9;
  localparam int OFS_W  = 16;
  localparam int HI_W   = OFS_W - DATA_W;

  logic clk = 1'b0;
  logic rst_n, ld_n, wr_en_n, rd_en_n;
  logic [DATA_W-1:0] din;
  logic [DATA_W-1:0] cfg_q;
  logic [OFS_W-1:0]  empty_ofs, full_ofs;
  logic prog_mode, fifo_wr_req, fifo_rd_req;

  always #4 clk = ~clk;

  flag_ofs_loader uut (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n),
    .din(din), .cfg_q(cfg_q), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
    .prog_mode(prog_mode), .fifo_wr_req(fifo_wr_req), .fifo_rd_req(fifo_rd_req)
  );

  int checks = 0;
  int errors = 0;
  logic [DATA_W-1:0] m_reg [4];
  int               m_sel;
  logic             m_armed, m_prog;
  logic [DATA_W-1:0] exp_q [$];
  logic [DATA_W-1:0] exp_cfg;
  logic             mon_on = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [OFS_W-1:0] mk(input int lo, input int hi);
    return {m_reg[hi][HI_W-1:0], m_reg[lo]};
  endfunction

  task automatic chk_ofs(input string req);
    chk({req, " empty_ofs"}, 32'(empty_ofs), 32'(mk(0, 1)));
    chk({req, " full_ofs"},  32'(full_ofs),  32'(mk(2, 3)));
  endtask

  // Scoreboard monitor: pop expected readback, compare cfg_q every cycle
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      while (exp_q.size() > 0) exp_cfg = exp_q.pop_front();
      chk("R6/R7 cfg_q", 32'(cfg_q), 32'(exp_cfg));
    end
  end

  task automatic do_reset(input logic mode_n);
    @(negedge clk);
    rst_n = 1'b0; ld_n = mode_n; wr_en_n = 1'b1; rd_en_n = 1'b1; din = '0;
    m_reg[0] = 9'd7; m_reg[1] = 9'd0; m_reg[2] = 9'd7; m_reg[3] = 9'd0;
    m_sel = 0; m_armed = 1'b0; m_prog = 1'b0;
    exp_q.delete(); exp_cfg = '0;
    repeat (2) @(negedge clk);
    chk("R1 reset empty_ofs", 32'(empty_ofs), 32'd7);
    chk("R1 reset full_ofs",  32'(full_ofs),  32'd7);
    chk("R1 reset cfg_q",     32'(cfg_q),     32'd0);
    rst_n = 1'b1;
    mon_on = 1'b1;
  endtask

  task automatic cyc(input logic l, input logic w, input logic r, input logic [DATA_W-1:0] d);
    logic wq, rq, load;
    @(negedge clk);
    ld_n = l; wr_en_n = w; rd_en_n = r; din = d;
    #1;
    load = m_prog && !l;
    chk("R9 fifo_wr_req", 32'(fifo_wr_req), 32'(m_armed && !w && !load));
    chk("R9 fifo_rd_req", 32'(fifo_rd_req), 32'(m_armed && !r && !load));
    @(posedge clk);
    #1;
    if (!m_armed) begin
      m_armed = 1'b1;
      m_prog  = !l;
    end else begin
      wq = m_prog && !l && !w;
      rq = m_prog && !l && !r && !wq;
      if (wq) m_reg[m_sel] = d;
      if (rq) exp_q.push_back(m_reg[m_sel]);
      if (wq || rq) m_sel = (m_sel + 1) % 4;
    end
    chk_ofs("R3/R8");
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ld_n = 1'b0; wr_en_n = 1'b1; rd_en_n = 1'b1; din = '0;
    // R1, R2: programming configuration
    do_reset(1'b0);
    cyc(1'b0, 1'b1, 1'b1, '0);           // configuration edge
    chk("R2 prog_mode", 32'(prog_mode), 32'd1);
    // R3: four writes in order
    cyc(1'b0, 1'b0, 1'b1, 9'h1A5);
    cyc(1'b0, 1'b0, 1'b1, 9'h003);
    cyc(1'b0, 1'b0, 1'b1, 9'h0F0);
    cyc(1'b0, 1'b0, 1'b1, 9'h07F);
    chk("R3 empty assembled", 32'(empty_ofs), 32'h07A5);
    chk("R3 full assembled",  32'(full_ofs),  32'hFEF0);
    // R4: fifth write wraps to empty-low
    cyc(1'b0, 1'b0, 1'b1, 9'h055);
    chk("R4 wrap empty_ofs", 32'(empty_ofs), 32'h0655);
    // R8: idle in load window
    cyc(1'b0, 1'b1, 1'b1, 9'h1FF);
    // R5, R9: normal FIFO cycles, then continue session at empty-high
    cyc(1'b1, 1'b0, 1'b1, 9'h1FF);
    cyc(1'b1, 1'b1, 1'b0, 9'h1FF);
    cyc(1'b0, 1'b0, 1'b1, 9'h011);
    chk("R5 continue at empty-high", 32'(empty_ofs), 32'h2255);
    // R6: readback from full-low onward through wrap
    cyc(1'b0, 1'b1, 1'b0, '0);
    cyc(1'b0, 1'b1, 1'b0, '0);
    cyc(1'b0, 1'b1, 1'b0, '0);
    cyc(1'b0, 1'b1, 1'b0, '0);
    cyc(1'b0, 1'b1, 1'b1, '0);
    chk("R6 readback last", 32'(cfg_q), 32'h011);
    // R7: write wins over read; selector now at full-low
    cyc(1'b0, 1'b0, 1'b0, 9'h0AA);
    chk("R7 write taken full_ofs", 32'(full_ofs), 32'hFEAA);
    cyc(1'b0, 1'b1, 1'b0, '0);           // reads full-high: one step only
    cyc(1'b0, 1'b1, 1'b1, '0);
    chk("R7 single step", 32'(cfg_q), 32'h07F);
    // R10: reset mid-session returns selector to empty-low
    cyc(1'b0, 1'b0, 1'b1, 9'h0C3);       // empty-low written, selector at empty-high
    do_reset(1'b0);
    cyc(1'b0, 1'b1, 1'b1, '0);
    cyc(1'b0, 1'b0, 1'b1, 9'h123);
    chk("R10 write lands on empty-low", 32'(empty_ofs), 32'h0123);
    // R2: expansion configuration
    do_reset(1'b1);
    cyc(1'b1, 1'b1, 1'b1, '0);
    chk("R2 expansion prog_mode", 32'(prog_mode), 32'd0);
    cyc(1'b0, 1'b0, 1'b1, 9'h1EE);
    cyc(1'b0, 1'b1, 1'b0, 9'h1EE);
    chk("R2 expansion frozen", 32'(empty_ofs), 32'd7);
    cyc(1'b1, 1'b1, 1'b1, '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule